// File: doc/BRIEF.md
# Serial Port Interrupt Identifier

This block folds the interrupt conditions of a 16550-style serial port into a single interrupt request and a byte that names the most urgent pending cause. Detector logic elsewhere in the port supplies five raw conditions. Four of them are levels: receiver line error, received data available, character timeout and modem status change. The fifth, transmit holding register empty, arrives as a one-cycle event. The interrupt-enable register supplies four enable bits, and a flag reports whether the FIFOs are on.

The block registers each condition once, gates it with its enable and resolves priority. The host reads the result as the identification byte. Reading that byte while it reports a transmit-empty interrupt acknowledges and clears that interrupt. A write to the transmit holding register also clears it. The block has no data stream, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `serial_irq_ident`

## Requirements
- R1: After reset, with all condition flags cleared, `irq_o` is 0 and `iid_o` is 8'h01.
- R2: A receiver line error enabled by `ien_i[2]` is reported with code 4'b0110 in `iid_o[3:0]`, ahead of every other source.
- R3: Received data available is enabled by `ien_i[0]`, is reported with code 4'b0100, and outranks a pending character timeout.
- R4: Character timeout is also enabled by `ien_i[0]`, is reported with code 4'b1100, and is ignored while `fifo_en_i` is 0.
- R5: Transmit holding register empty is enabled by `ien_i[1]`, is reported with code 4'b0010, and ranks third, below line status and received data.
- R6: Modem status change is enabled by `ien_i[3]`, is reported with code 4'b0000, and has the lowest rank.
- R7: `irq_o` is 1 exactly when at least one enabled source is pending. When none is pending, `iid_o[3:0]` is 4'b0001.
- R8: `iid_o[7:6]` reads 2'b11 while `fifo_en_i` (as registered) is 1 and 2'b00 otherwise. `iid_o[5:4]` is always 2'b00.
- R9: Asserting `id_rd_i` in a cycle where `iid_o[3:0]` is 4'b0010 clears the pending transmit-empty interrupt. A read while another code is shown leaves it pending.
- R10: Asserting `thr_wr_i` clears the pending transmit-empty interrupt. It is raised again only by a new `thr_empty_evt_i` pulse. If an event and a clear fall in the same cycle, the event wins.
- R11: Conditions and `fifo_en_i` are sampled at a clock edge, and the outputs reflect them from that edge on. Enable bits act on the outputs without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ien_i | input | 4 | Enables: [0] rx data and timeout, [1] transmit empty, [2] line status, [3] modem |
| fifo_en_i | input | 1 | FIFOs enabled |
| line_err_i | input | 1 | Receiver line error pending (level) |
| rx_avail_i | input | 1 | Received data available (level) |
| char_tmo_i | input | 1 | Character timeout pending (level) |
| thr_empty_evt_i | input | 1 | Transmit holding register became empty (one-cycle pulse) |
| modem_chg_i | input | 1 | Modem status changed (level) |
| id_rd_i | input | 1 | Identification byte is being read this cycle |
| thr_wr_i | input | 1 | Transmit holding register is being written this cycle |
| irq_o | output | 1 | Interrupt request |
| iid_o | output | 8 | Identification byte |

## Verification
The bench aims at the priority ladder with several sources pending at once. A design with a misordered chain would show the wrong code, for example timeout instead of received data. The bench also checks the shared enable bit, and a timeout that slips through with FIFOs off would show 4'b1100 where 4'b0001 or the modem code is expected. The acknowledge path is tested by reading while line status hides a pending transmit-empty interrupt. A design that clears on any read would lose that interrupt. A design whose clear beats a simultaneous new event would drop it.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;
  localparam int CODE_W = 4;
  localparam int IEN_W  = 4;

  localparam logic [CODE_W-1:0] CODE_NONE  = 4'b0001;
  localparam logic [CODE_W-1:0] CODE_LINE  = 4'b0110;
  localparam logic [CODE_W-1:0] CODE_RXD   = 4'b0100;
  localparam logic [CODE_W-1:0] CODE_TMO   = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_THRE  = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_MODEM = 4'b0000;

  // bit positions inside the enable vector
  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  typedef struct packed {
    logic line;
    logic rxd;
    logic tmo;
    logic thre;
    logic modem;
  } src_flags_t;
endpackage

// File: rtl/serial_irq_lvl_reg.sv
module serial_irq_lvl_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q_o[g] <= 1'b0;
      else        q_o[g] <= d_i[g];
    end
  end
endmodule

// File: rtl/serial_irq_thre_track.sv
module serial_irq_thre_track (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;   // a fresh event outranks an acknowledge
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/serial_irq_prio.sv
module serial_irq_prio
  import serial_irq_pkg::*;
(
  input  src_flags_t        flags_i,
  input  logic [IEN_W-1:0]  ien_i,
  input  logic              fifo_i,
  output logic [CODE_W-1:0] code_o,
  output logic              irq_o
);
  logic act_line, act_rxd, act_tmo, act_thre, act_modem;

  always_comb begin
    act_line  = flags_i.line  & ien_i[EN_LINE];
    act_rxd   = flags_i.rxd   & ien_i[EN_RX];
    act_tmo   = flags_i.tmo   & ien_i[EN_RX] & fifo_i;
    act_thre  = flags_i.thre  & ien_i[EN_THRE];
    act_modem = flags_i.modem & ien_i[EN_MODEM];

    irq_o = act_line | act_rxd | act_tmo | act_thre | act_modem;

    if (act_line)       code_o = CODE_LINE;
    else if (act_rxd)   code_o = CODE_RXD;
    else if (act_tmo)   code_o = CODE_TMO;
    else if (act_thre)  code_o = CODE_THRE;
    else if (act_modem) code_o = CODE_MODEM;
    else                code_o = CODE_NONE;
  end
endmodule

// File: rtl/serial_irq_ident.sv
module serial_irq_ident
  import serial_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IEN_W-1:0] ien_i,
  input  logic             fifo_en_i,
  input  logic             line_err_i,
  input  logic             rx_avail_i,
  input  logic             char_tmo_i,
  input  logic             thr_empty_evt_i,
  input  logic             modem_chg_i,
  input  logic             id_rd_i,
  input  logic             thr_wr_i,
  output logic             irq_o,
  output logic [7:0]       iid_o
);
  localparam int LVL_W = 5;

  logic [LVL_W-1:0]  lvl_q;
  logic              thre_pend;
  logic              thre_clr;
  logic [CODE_W-1:0] code;
  src_flags_t        flags;

  serial_irq_lvl_reg #(.W(LVL_W)) u_lvl (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({fifo_en_i, line_err_i, rx_avail_i, char_tmo_i, modem_chg_i}),
    .q_o   (lvl_q)
  );

  always_comb begin
    flags.line  = lvl_q[3];
    flags.rxd   = lvl_q[2];
    flags.tmo   = lvl_q[1];
    flags.modem = lvl_q[0];
    flags.thre  = thre_pend;
  end

  assign thre_clr = thr_wr_i | (id_rd_i & (code == CODE_THRE));

  serial_irq_thre_track u_thre (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (thr_empty_evt_i),
    .clr_i  (thre_clr),
    .pend_o (thre_pend)
  );

  serial_irq_prio u_prio (
    .flags_i (flags),
    .ien_i   (ien_i),
    .fifo_i  (lvl_q[4]),
    .code_o  (code),
    .irq_o   (irq_o)
  );

  assign iid_o = {{2{lvl_q[4]}}, 2'b00, code};
endmodule

// File: rtl/serial_irq_ident_chk.sv
module serial_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ien_i,
  input logic       line_err_i,
  input logic       thr_empty_evt_i,
  input logic       id_rd_i,
  input logic       thr_wr_i,
  input logic       irq_o,
  input logic [7:0] iid_o
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_IRQ_CODE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (iid_o[3:0] != 4'b0001)); // R7

  AST_NO_IRQ_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_i == 4'b0000) |-> !irq_o); // R7

  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(line_err_i) && ien_i[2]) |-> iid_o[3:0] == 4'b0110); // R2

  AST_TMO_NEEDS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_o[3:0] == 4'b1100) |-> iid_o[7:6] == 2'b11); // R4

  AST_UPPER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_o[5:4] == 2'b00) && (iid_o[7] == iid_o[6])); // R8

  AST_READ_ACK_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(id_rd_i && iid_o[3:0] == 4'b0010 && !thr_empty_evt_i))
      |-> iid_o[3:0] != 4'b0010); // R9

  AST_WRITE_ACK_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(thr_wr_i && !thr_empty_evt_i)) |-> iid_o[3:0] != 4'b0010); // R10
endmodule

bind serial_irq_ident serial_irq_ident_chk chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .ien_i           (ien_i),
  .line_err_i      (line_err_i),
  .thr_empty_evt_i (thr_empty_evt_i),
  .id_rd_i         (id_rd_i),
  .thr_wr_i        (thr_wr_i),
  .irq_o           (irq_o),
  .iid_o           (iid_o)
);

// File: tb/serial_irq_ident_tb_top.sv
module serial_irq_ident_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ien = '0;
  logic       fifo_en = 1'b0, line_err = 1'b0, rx_avail = 1'b0, char_tmo = 1'b0;
  logic       thre_evt = 1'b0, modem_chg = 1'b0, id_rd = 1'b0, thr_wr = 1'b0;
  logic       irq;
  logic [7:0] iid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  serial_irq_ident dut_i (
    .clk(clk), .rst_n(rst_n), .ien_i(ien), .fifo_en_i(fifo_en),
    .line_err_i(line_err), .rx_avail_i(rx_avail), .char_tmo_i(char_tmo),
    .thr_empty_evt_i(thre_evt), .modem_chg_i(modem_chg), .id_rd_i(id_rd),
    .thr_wr_i(thr_wr), .irq_o(irq), .iid_o(iid)
  );

  // {enables, fifo, line, rxd, tmo, modem, expected iid}
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {4'hF, 1'b0, 4'b0000, 8'h01},  // R7 nothing pending
    {4'hF, 1'b0, 4'b1111, 8'h06},  // R2 line wins over all
    {4'hB, 1'b0, 4'b1111, 8'h04},  // R3 rx data next
    {4'hB, 1'b1, 4'b0011, 8'hCC},  // R4 timeout with fifo
    {4'hB, 1'b0, 4'b0011, 8'h00},  // R4 timeout ignored, modem shown R6
    {4'hE, 1'b1, 4'b0111, 8'hC0},  // R3 shared enable off hides both
    {4'h1, 1'b1, 4'b0110, 8'hC4},  // R3 rx data ahead of timeout
    {4'h4, 1'b0, 4'b1000, 8'h06},  // R2 line alone
    {4'h0, 1'b0, 4'b1000, 8'h01},  // R7 line disabled
    {4'h8, 1'b0, 4'b0001, 8'h00},  // R6 modem alone raises irq
    {4'h7, 1'b1, 4'b0001, 8'hC1},  // R8 fifo bits, modem masked
    {4'h1, 1'b0, 4'b0010, 8'h01}   // R4 timeout without fifo
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    logic exp_irq;
    exp_irq = (exp[3:0] != 4'b0001);
    checks++;
    if (iid !== exp || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s: iid=%h irq=%b expected iid=%h irq=%b", req, iid, irq, exp, exp_irq);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ien = 4'hF;
    chk("R1 reset state", 8'h01);

    for (int i = 0; i < NV; i++) begin
      {ien, fifo_en, line_err, rx_avail, char_tmo, modem_chg} = VEC[i][16:8];
      step();
      chk($sformatf("R2-table vector %0d", i), VEC[i][7:0]);
    end
    {line_err, rx_avail, char_tmo, modem_chg, fifo_en} = '0;

    // R11: change visible only after the next edge
    ien = 4'h4;
    step();
    line_err = 1'b1;
    #1 chk("R11 before edge", 8'h01);
    step();
    chk("R11 after edge", 8'h06);
    line_err = 1'b0;
    step();

    // R5 / R9: transmit empty raised, acknowledged by read
    ien = 4'h2;
    thre_evt = 1'b1; step(); thre_evt = 1'b0;
    chk("R5 thre raised", 8'h02);
    id_rd = 1'b1; step(); id_rd = 1'b0;
    chk("R9 read clears thre", 8'h01);
    id_rd = 1'b1; step(); id_rd = 1'b0;
    chk("R10 no re-raise without event", 8'h01);

    // R10: write clears
    thre_evt = 1'b1; step(); thre_evt = 1'b0;
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    chk("R10 write clears thre", 8'h01);

    // R9: read while line status hides thre leaves it pending
    ien = 4'h6;
    thre_evt = 1'b1; line_err = 1'b1; step(); thre_evt = 1'b0;
    chk("R5 line above thre", 8'h06);
    id_rd = 1'b1; step(); id_rd = 1'b0;
    line_err = 1'b0; step();
    chk("R9 hidden thre kept", 8'h02);

    // R10: event and write together, event wins
    thr_wr = 1'b1; thre_evt = 1'b1; step(); thr_wr = 1'b0; thre_evt = 1'b0;
    chk("R10 event beats clear", 8'h02);

    // R5 thre below rx data, above modem
    ien = 4'hB; rx_avail = 1'b1; modem_chg = 1'b1; step();
    chk("R5 rx above thre", 8'h04);
    rx_avail = 1'b0; step();
    chk("R6 thre above modem", 8'h02);
    ien = 4'h9; #1 chk("R11 enable acts at once", 8'h00);
    modem_chg = 1'b0; step();
    chk("R7 idle again", 8'h01);

    // R1: reset mid-run clears pending thre
    ien = 4'h2; rst_n = 1'b0; step(); rst_n = 1'b1;
    chk("R1 reset clears thre", 8'h01);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule